// File: doc/BRIEF.md
# Shifter with Carry and Extend Flags

This block shifts a 32-bit operand left logically, right logically or right arithmetically by a 6-bit count. It also produces the condition flags that a shift instruction leaves behind: carry (C), extend (X), negative (N), zero (Z) and overflow (V). Counts are not reduced modulo the word width. A count of 32 or more empties the word in a defined way, and each of those ranges has its own carry rule. A zero count leaves the operand unchanged and passes the caller's previous carry into both C and X.

The integer pipeline places the unit in its execute stage. Operand, count, shift kind and previous carry are presented together. The result and all flags appear, registered, one clock later. There is no valid or stall signal, so a new operation may be presented on every cycle.

Top module: `shift_cx_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first clock edge, every output is 0. After that, each output reflects the inputs sampled at the previous rising clock edge.
- R2: The full 6-bit count value from 0 to 63 is used as the shift amount, with no further reduction. Counts of 32 and above never wrap into a smaller shift.
- R3: For a count of 0 and any shift kind other than the reserved one, the result equals the operand, and C and X both equal `carry_in`.
- R4: `kind` = 2'b00 (logical left) with a count n from 1 to 31 gives operand << n, zero-filled. C is operand bit (32 - n).
- R5: Logical left with a count of exactly 32 gives a result of 0 and C equal to operand bit 0. A count from 33 to 63 gives 0 with C = 0.
- R6: `kind` = 2'b01 (logical right) with a count n from 1 to 31 gives operand >> n, zero-filled, and C is operand bit (n - 1). A count of 32 gives 0 with C equal to operand bit 31. A count from 33 to 63 gives 0 with C = 0.
- R7: `kind` = 2'b10 (arithmetic right) with a count n from 1 to 31 fills from the left with operand bit 31, and C is operand bit (n - 1). A count of 32 or more makes every result bit equal to operand bit 31, and C equals that bit.
- R8: X always equals the C produced by the same operation.
- R9: N equals result bit 31, Z is 1 exactly when the result is 0, and V is always 0.
- R10: `kind` = 2'b11 is reserved. The result equals the operand for every count, and C and X equal `carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| operand | input | 32 | Value to shift |
| count | input | 6 | Shift amount, 0 to 63 |
| kind | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 reserved |
| carry_in | input | 1 | C flag left by the previous operation |
| result | output | 32 | Shifted value |
| c_flag | output | 1 | Carry: last bit shifted out, or `carry_in` when nothing is shifted |
| x_flag | output | 1 | Extend, a copy of C |
| n_flag | output | 1 | Negative, result bit 31 |
| z_flag | output | 1 | Zero, result equals 0 |
| v_flag | output | 1 | Overflow, always 0 |

## Verification
Every output comes from one register stage. Inputs applied before a rising edge are therefore reflected in `result` and in all five flags after that same edge, and in no earlier cycle. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, half a period after the edge that captured them. Each sample therefore belongs to exactly one operation. The bench sweeps every count, every kind and both carry values over a set of operands chosen to expose edge bits and the sign bit. Its expected values come from 64-bit shifts of the operand placed in the upper or lower half of a double-width word.

// File: rtl/shift_cx_pkg.sv
package shift_cx_pkg;
  typedef enum logic [1:0] {
    SHK_LSL = 2'b00,
    SHK_LSR = 2'b01,
    SHK_ASR = 2'b10,
    SHK_RSV = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/shift_cx_barrel.sv
// Logarithmic shifter. Amounts up to 2*W-1 are accepted; anything of W or
// more leaves only fill bits (zero for left shifts, fill for right shifts).
module shift_cx_barrel #(
  parameter int W  = 32,
  parameter int AW = 6
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          to_left,
  input  logic          fill,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [AW+1];

  assign stage[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [2*W-1:0] wide_r;
    logic [2*W-1:0] wide_l;
    assign wide_r = {{W{fill}}, stage[k]} >> STEP;
    assign wide_l = {stage[k], {W{1'b0}}} << STEP;
    assign stage[k+1] = amt[k] ? (to_left ? wide_l[2*W-1:W] : wide_r[W-1:0])
                               : stage[k];
  end

  assign dout = stage[AW];
endmodule

// File: rtl/shift_cx_flags.sv
// Sign and zero detection on the value about to be registered.
module shift_cx_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  output logic         neg,
  output logic         zero
);
  assign neg  = value[W-1];
  assign zero = (value == '0);
endmodule

// File: rtl/shift_cx_unit.sv
module shift_cx_unit
  import shift_cx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] operand,
  input  logic [CNT_W-1:0]  count,
  input  logic [1:0]        kind,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              c_flag,
  output logic              x_flag,
  output logic              n_flag,
  output logic              z_flag,
  output logic              v_flag
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  shift_kind_e      kind_e;
  logic             go_left;
  logic             fill_bit;
  logic [CNT_W-1:0] count_m1;
  logic [DATA_W-1:0] main_shift;
  logic [DATA_W-1:0] last_shift;
  logic              idle_shift;

  logic [DATA_W-1:0] res_d, res_q;
  logic              c_d, c_q, x_d, x_q, n_d, n_q, z_d, z_q;

  assign kind_e     = shift_kind_e'(kind);
  assign go_left    = (kind_e == SHK_LSL);
  assign fill_bit   = (kind_e == SHK_ASR) & operand[DATA_W-1];
  assign count_m1   = count - CNT_ONE;
  assign idle_shift = (kind_e == SHK_RSV) || (count == '0);

  // Full shift gives the result.
  shift_cx_barrel #(.W(DATA_W), .AW(CNT_W)) main_i (
    .din(operand), .amt(count), .to_left(go_left), .fill(fill_bit),
    .dout(main_shift)
  );

  // Shift by one less exposes the last bit pushed out at the edge.
  shift_cx_barrel #(.W(DATA_W), .AW(CNT_W)) last_i (
    .din(operand), .amt(count_m1), .to_left(go_left), .fill(fill_bit),
    .dout(last_shift)
  );

  always_comb begin
    if (idle_shift) begin
      res_d = operand;
      c_d   = carry_in;
    end else begin
      res_d = main_shift;
      c_d   = go_left ? last_shift[DATA_W-1] : last_shift[0];
    end
    x_d = c_d;
  end

  shift_cx_flags #(.W(DATA_W)) flags_i (
    .value(res_d), .neg(n_d), .zero(z_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      c_q   <= 1'b0;
      x_q   <= 1'b0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
    end else begin
      res_q <= res_d;
      c_q   <= c_d;
      x_q   <= x_d;
      n_q   <= n_d;
      z_q   <= z_d;
    end
  end

  assign result = res_q;
  assign c_flag = c_q;
  assign x_flag = x_q;
  assign n_flag = n_q;
  assign z_flag = z_q;
  assign v_flag = 1'b0;

  // ---------------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------------
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R3
  zero_count_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(count) == '0)
      |-> (result == $past(operand) && c_flag == $past(carry_in)));

  // R5
  left_wide_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(kind) == SHK_LSL && $past(count) > CNT_W'(DATA_W))
      |-> (result == '0 && !c_flag));

  // R7
  sar_wide_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(kind) == SHK_ASR && $past(count) >= CNT_W'(DATA_W))
      |-> (result == {DATA_W{$past(operand[DATA_W-1])}}
           && c_flag == $past(operand[DATA_W-1])));

  // R10
  reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(kind) == SHK_RSV)
      |-> (result == $past(operand) && x_flag == $past(carry_in)));

  // R9
  neg_matches_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (n_flag == result[DATA_W-1] && z_flag == (result == '0)));
endmodule

// File: tb/shift_cx_unit_tb.sv
module shift_cx_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] operand = '0;
  logic [5:0]   count = '0;
  logic [1:0]   kind = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] result;
  logic         c_flag, x_flag, n_flag, z_flag, v_flag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  shift_cx_unit dut_i (
    .clk(clk), .rst_n(rst_n), .operand(operand), .count(count),
    .kind(kind), .carry_in(carry_in), .result(result), .c_flag(c_flag),
    .x_flag(x_flag), .n_flag(n_flag), .z_flag(z_flag), .v_flag(v_flag)
  );

  function automatic string tag_for(input logic [1:0] k, input int n);
    if (k == 2'b11)      return "R10";
    if (n == 0)          return "R3";
    if (k == 2'b00)      return (n < 32) ? "R4" : ((n == 32) ? "R5" : "R5 R2");
    if (k == 2'b01)      return (n > 32) ? "R6 R2" : "R6";
    return (n > 32) ? "R7 R2" : "R7";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [W-1:0] op, input int n,
                         input logic [1:0] k, input logic pc);
    logic [2*W-1:0] wide;
    logic [W-1:0]   exp_res;
    logic           exp_c;
    string          t;
    @(negedge clk);
    operand = op; count = 6'(n); kind = k; carry_in = pc;
    if (k == 2'b11 || n == 0) begin
      exp_res = op;
      exp_c   = pc;
    end else if (k == 2'b00) begin
      wide    = {{W{1'b0}}, op} << n;
      exp_res = wide[W-1:0];
      exp_c   = wide[W];
    end else if (k == 2'b01) begin
      wide    = {op, {W{1'b0}}} >> n;
      exp_res = wide[2*W-1:W];
      exp_c   = wide[W-1];
    end else begin
      wide    = $unsigned($signed({op, {W{1'b0}}}) >>> n);
      exp_res = wide[2*W-1:W];
      exp_c   = wide[W-1];
    end
    t = tag_for(k, n);
    @(negedge clk);
    check(t, "result", result, exp_res);
    check(t, "C", {31'b0, c_flag}, {31'b0, exp_c});
    check("R8", "X", {31'b0, x_flag}, {31'b0, exp_c});
    check("R9", "NZV", {29'b0, n_flag, z_flag, v_flag},
          {29'b0, exp_res[W-1], (exp_res == '0), 1'b0});
  endtask

  localparam logic [W-1:0] PATS [8] = '{
    32'h8000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678,
    32'hA5A5_A5A5, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000
  };

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    operand = 32'hDEAD_BEEF; count = 6'd5; kind = 2'b01; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "result@reset", result, '0);
    check("R1", "flags@reset", {27'b0, c_flag, x_flag, n_flag, z_flag, v_flag}, '0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 8; p++)
        for (int n = 0; n < 64; n++)
          for (int c = 0; c < 2; c++)
            run_vec(PATS[p], n, 2'(k), c[0]);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule